// File: doc/BRIEF.md
# FIFO Threshold Interrupt Logic

This block sits beside the host-side read and write data FIFOs of a storage
controller. It compares the two FIFO occupancy counts against programmable
thresholds, turns the results into request bits together with three other
interrupt sources, and merges the enabled requests into a single interrupt
line. The three other sources are the attached device's interrupt line, a
transfer-terminated event and a bus-timeout event.

Software writes one threshold/request register and one enable register.
The threshold/request register holds the read threshold, the write threshold
and the request bits. Writing this register loads both thresholds and, in the
same write, clears every request bit at which a 1 is written. FIFO and device
requests follow a level condition: a request cleared while its condition
still holds comes back one clock later. Termination and timeout requests are
sticky events. Two status outputs report write FIFO full and read FIFO empty
directly from the occupancy counts.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset the read threshold is 8, the write threshold is 24 (write depth 32 minus 8), all request and enable bits are 0, and `irq_o` is 0, so `thr_rdata_o` reads 0x0018_0008.
- R2: A write to the threshold register loads the read threshold from bits [9:0] and the write threshold from bits [25:16]. A value above 8 in the read field is saturated to 8. A value above 32 in the write field is saturated to 32.
- R3: Request bit 10 (read almost full) is set one clock after the read level is at or above the read threshold. Request bit 11 (read not empty) is set one clock after the read level is non-zero.
- R4: Request bit 12 (write almost empty) is set one clock after the write level is at or below the write threshold. Request bit 13 (write not full) is set one clock after the write level is below 32.
- R5: Request bit 15 is set one clock after `dev_irq_i` is high.
- R6: A one-cycle pulse on `xfer_term_i` sets request bit 28, and a one-cycle pulse on `bus_tmo_i` sets request bit 29. Both bits stay set after the pulse ends, until software clears them.
- R7: Writing 1 to a request bit position clears that bit, and writing 0 there leaves it unchanged. A level request (bit 10, 11, 12, 13 or 15) whose condition still holds reads 0 for one clock after the clear and 1 again on the next clock.
- R8: A termination or timeout event that arrives in the same cycle as a clear of its bit leaves the bit set.
- R9: `irq_o` is high exactly when at least one request is set together with its enable. The enable-to-request pairs are: enable bits 9, 10, 11 and 12 to request bits 10, 11, 12 and 13; enable 14 to request 29; enable 15 to request 15; enable 28 to request 28.
- R10: `stat_wr_full_o` is high when the write level is 32 or more, and `stat_rd_empty_o` is high when the read level is 0. Both follow the level inputs in the same cycle.
- R11: The enable register keeps only bits 9–12, 14, 15 and 28. All other bits read 0, so writing all ones reads back 0x1000_DE00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_level_i | input | RD_LVL_W (6) | Read FIFO occupancy |
| wr_level_i | input | WR_LVL_W (6) | Write FIFO occupancy |
| dev_irq_i | input | 1 | Device interrupt line |
| xfer_term_i | input | 1 | Transfer terminated event pulse |
| bus_tmo_i | input | 1 | Bus timeout event pulse |
| thr_we_i | input | 1 | Write strobe, threshold/request register |
| thr_wdata_i | input | 32 | Threshold/request write data (thresholds, W1C request bits) |
| en_we_i | input | 1 | Write strobe, enable register |
| en_wdata_i | input | 32 | Enable write data |
| thr_rdata_o | output | 32 | Thresholds and request bits |
| en_rdata_o | output | 32 | Enable bits |
| stat_wr_full_o | output | 1 | Write FIFO full |
| stat_rd_empty_o | output | 1 | Read FIFO empty |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench uses the default parameters: both FIFOs 32 deep, a read threshold limit of 8, and 10-bit threshold fields. With these values, random levels from 0 to 32 reach both ends of every comparison: empty, full, exactly at a threshold, and one step either side of it. The saturating threshold fields can be driven past both limits. Random clears collide with events and with conditions that are still active, which exercises the clear-then-return timing of level requests and the rule that an event beats a clear in the same cycle.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned WR_THR_LSB = 16;
  localparam int unsigned NSRC       = 7;

  // source index: 0 rd_af, 1 rd_ne, 2 wr_ae, 3 wr_nf, 4 dev, 5 term, 6 tmo
  localparam int unsigned REQ_POS [NSRC] = '{10, 11, 12, 13, 15, 28, 29};
  localparam int unsigned EN_POS  [NSRC] = '{9, 10, 11, 12, 15, 28, 14};
  localparam logic [NSRC-1:0] SRC_LEVEL = 7'b001_1111;

  localparam logic [REG_W-1:0] REQ_MASK = 32'h3000_BC00;
  localparam logic [REG_W-1:0] EN_MASK  = 32'h1000_DE00;
endpackage

// File: rtl/fifo_irq_lvl_cmp.sv
module fifo_irq_lvl_cmp #(
  parameter int unsigned RD_DEPTH = 32,
  parameter int unsigned WR_DEPTH = 32,
  parameter int unsigned THR_W    = 10,
  localparam int unsigned RD_LVL_W = $clog2(RD_DEPTH + 1),
  localparam int unsigned WR_LVL_W = $clog2(WR_DEPTH + 1)
) (
  input  logic [RD_LVL_W-1:0] rd_level_i,
  input  logic [WR_LVL_W-1:0] wr_level_i,
  input  logic [THR_W-1:0]    rd_thr_i,
  input  logic [THR_W-1:0]    wr_thr_i,
  output logic                rd_af_o,
  output logic                rd_ne_o,
  output logic                wr_ae_o,
  output logic                wr_nf_o,
  output logic                wr_full_o,
  output logic                rd_empty_o
);
  logic [THR_W-1:0] rd_lvl_x, wr_lvl_x;

  assign rd_lvl_x   = THR_W'(rd_level_i);
  assign wr_lvl_x   = THR_W'(wr_level_i);
  assign rd_af_o    = rd_lvl_x >= rd_thr_i;
  assign rd_ne_o    = rd_level_i != '0;
  assign wr_ae_o    = wr_lvl_x <= wr_thr_i;
  assign wr_full_o  = wr_lvl_x >= THR_W'(WR_DEPTH);
  assign wr_nf_o    = !wr_full_o;
  assign rd_empty_o = !rd_ne_o;
endmodule

// File: rtl/fifo_irq_req_bit.sv
module fifo_irq_req_bit #(
  parameter bit LEVEL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  generate
    if (LEVEL) begin : g_level
      // clear wins this cycle; live condition re-sets next cycle
      assign q_d = (q_o | set_i) & ~clr_i;
    end else begin : g_event
      // an event never gets lost to a concurrent clear
      assign q_d = (q_o & ~clr_i) | set_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/fifo_irq_regs.sv
module fifo_irq_regs
  import fifo_irq_pkg::*;
#(
  parameter int unsigned WR_DEPTH   = 32,
  parameter int unsigned RD_THR_MAX = 8,
  parameter int unsigned THR_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             thr_we_i,
  input  logic [REG_W-1:0] thr_wdata_i,
  input  logic             en_we_i,
  input  logic [REG_W-1:0] en_wdata_i,
  output logic [THR_W-1:0] rd_thr_o,
  output logic [THR_W-1:0] wr_thr_o,
  output logic [NSRC-1:0]  en_o
);
  localparam logic [THR_W-1:0] RD_MAX  = THR_W'(RD_THR_MAX);
  localparam logic [THR_W-1:0] WR_MAX  = THR_W'(WR_DEPTH);
  localparam logic [THR_W-1:0] WR_INIT = THR_W'(WR_DEPTH - RD_THR_MAX);

  logic [THR_W-1:0] rd_fld, wr_fld, rd_sat, wr_sat;
  logic [NSRC-1:0]  en_d;

  assign rd_fld = thr_wdata_i[THR_W-1:0];
  assign wr_fld = thr_wdata_i[WR_THR_LSB +: THR_W];
  assign rd_sat = (rd_fld > RD_MAX) ? RD_MAX : rd_fld;
  assign wr_sat = (wr_fld > WR_MAX) ? WR_MAX : wr_fld;

  for (genvar i = 0; i < NSRC; i++) begin : g_en
    assign en_d[i] = en_wdata_i[EN_POS[i]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_thr_o <= RD_MAX;
      wr_thr_o <= WR_INIT;
    end else if (thr_we_i) begin
      rd_thr_o <= rd_sat;
      wr_thr_o <= wr_sat;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (en_we_i) en_o <= en_d;
  end
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int unsigned RD_DEPTH   = 32,
  parameter int unsigned WR_DEPTH   = 32,
  parameter int unsigned RD_THR_MAX = 8,
  parameter int unsigned THR_W      = 10,
  localparam int unsigned RD_LVL_W  = $clog2(RD_DEPTH + 1),
  localparam int unsigned WR_LVL_W  = $clog2(WR_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [RD_LVL_W-1:0] rd_level_i,
  input  logic [WR_LVL_W-1:0] wr_level_i,
  input  logic                dev_irq_i,
  input  logic                xfer_term_i,
  input  logic                bus_tmo_i,
  input  logic                thr_we_i,
  input  logic [31:0]         thr_wdata_i,
  input  logic                en_we_i,
  input  logic [31:0]         en_wdata_i,
  output logic [31:0]         thr_rdata_o,
  output logic [31:0]         en_rdata_o,
  output logic                stat_wr_full_o,
  output logic                stat_rd_empty_o,
  output logic                irq_o
);
  logic [THR_W-1:0] rd_thr, wr_thr;
  logic [NSRC-1:0]  en, src, req;

  fifo_irq_regs #(
    .WR_DEPTH  (WR_DEPTH),
    .RD_THR_MAX(RD_THR_MAX),
    .THR_W     (THR_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .thr_we_i   (thr_we_i),
    .thr_wdata_i(thr_wdata_i),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .rd_thr_o   (rd_thr),
    .wr_thr_o   (wr_thr),
    .en_o       (en)
  );

  fifo_irq_lvl_cmp #(
    .RD_DEPTH(RD_DEPTH),
    .WR_DEPTH(WR_DEPTH),
    .THR_W   (THR_W)
  ) u_cmp (
    .rd_level_i(rd_level_i),
    .wr_level_i(wr_level_i),
    .rd_thr_i  (rd_thr),
    .wr_thr_i  (wr_thr),
    .rd_af_o   (src[0]),
    .rd_ne_o   (src[1]),
    .wr_ae_o   (src[2]),
    .wr_nf_o   (src[3]),
    .wr_full_o (stat_wr_full_o),
    .rd_empty_o(stat_rd_empty_o)
  );

  assign src[4] = dev_irq_i;
  assign src[5] = xfer_term_i;
  assign src[6] = bus_tmo_i;

  for (genvar i = 0; i < NSRC; i++) begin : g_req
    fifo_irq_req_bit #(.LEVEL(SRC_LEVEL[i])) u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (src[i]),
      .clr_i (thr_we_i & thr_wdata_i[REQ_POS[i]]),
      .q_o   (req[i])
    );
  end

  always_comb begin
    thr_rdata_o = '0;
    en_rdata_o  = '0;
    thr_rdata_o[THR_W-1:0]             = rd_thr;
    thr_rdata_o[WR_THR_LSB +: THR_W]   = wr_thr;
    for (int i = 0; i < NSRC; i++) begin
      thr_rdata_o[REQ_POS[i]] = req[i];
      en_rdata_o[EN_POS[i]]   = en[i];
    end
  end

  assign irq_o = |(req & en);
endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
module fifo_irq_ctrl_chk #(
  parameter int unsigned RD_LVL_W   = 6,
  parameter int unsigned RD_THR_MAX = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [RD_LVL_W-1:0] rd_level_i,
  input logic                xfer_term_i,
  input logic                bus_tmo_i,
  input logic                thr_we_i,
  input logic [31:0]         thr_wdata_i,
  input logic [31:0]         thr_rdata_o,
  input logic [31:0]         en_rdata_o,
  input logic                stat_rd_empty_o,
  input logic                irq_o
);
  assert_rd_thr_max_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_rdata_o[9:0] <= 10'(RD_THR_MAX));

  assert_rd_ne_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_level_i != '0 && !(thr_we_i && thr_wdata_i[11])) |=> thr_rdata_o[11]);

  assert_term_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_rdata_o[28] && !(thr_we_i && thr_wdata_i[28])) |=> thr_rdata_o[28]);

  assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_we_i && thr_wdata_i[12]) |=> !thr_rdata_o[12]);

  assert_evt_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_term_i || bus_tmo_i) |=> (thr_rdata_o[28] || thr_rdata_o[29]));

  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_rdata_o == 32'h0) |-> !irq_o);

  assert_rd_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_empty_o == (rd_level_i == '0));
endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(
  .RD_LVL_W  (RD_LVL_W),
  .RD_THR_MAX(RD_THR_MAX)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rd_level_i     (rd_level_i),
  .xfer_term_i    (xfer_term_i),
  .bus_tmo_i      (bus_tmo_i),
  .thr_we_i       (thr_we_i),
  .thr_wdata_i    (thr_wdata_i),
  .thr_rdata_o    (thr_rdata_o),
  .en_rdata_o     (en_rdata_o),
  .stat_rd_empty_o(stat_rd_empty_o),
  .irq_o          (irq_o)
);

// File: tb/fifo_irq_ctrl_tb.sv
module fifo_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  rd_level_i = '0, wr_level_i = '0;
  logic        dev_irq_i = 1'b0, xfer_term_i = 1'b0, bus_tmo_i = 1'b0;
  logic        thr_we_i = 1'b0, en_we_i = 1'b0;
  logic [31:0] thr_wdata_i = '0, en_wdata_i = '0;
  logic [31:0] thr_rdata_o, en_rdata_o;
  logic        stat_wr_full_o, stat_rd_empty_o, irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [9:0]  m_rd_thr, m_wr_thr;
  logic [31:0] m_req, m_en;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fifo_irq_ctrl u_dut (.*);

  function automatic logic [9:0] sat(logic [9:0] v, int unsigned mx);
    return (v > 10'(mx)) ? 10'(mx) : v;
  endfunction

  function automatic logic exp_irq(logic [31:0] r, logic [31:0] e);
    return (r[10] & e[9]) | (r[11] & e[10]) | (r[12] & e[11]) | (r[13] & e[12]) |
           (r[15] & e[15]) | (r[28] & e[28]) | (r[29] & e[14]);
  endfunction

  function automatic logic [31:0] exp_thr();
    logic [31:0] v;
    v = m_req;
    v[9:0]   = m_rd_thr;
    v[25:16] = m_wr_thr;
    return v;
  endfunction

  task automatic model_step();
    logic [31:0] cond, clr, lvl_m, nxt;
    cond = '0;
    cond[10] = {4'b0, rd_level_i} >= m_rd_thr;
    cond[11] = rd_level_i != 0;
    cond[12] = {4'b0, wr_level_i} <= m_wr_thr;
    cond[13] = wr_level_i < 32;
    cond[15] = dev_irq_i;
    clr   = thr_we_i ? (thr_wdata_i & 32'h3000_BC00) : 32'h0;
    lvl_m = 32'h0000_BC00;
    nxt   = (((m_req | cond) & ~clr) & lvl_m) |
            (((m_req & ~clr) | {2'b0, bus_tmo_i, xfer_term_i, 28'h0}) & ~lvl_m);
    m_req = nxt & 32'h3000_BC00;
    if (thr_we_i) begin
      m_rd_thr = sat(thr_wdata_i[9:0], 8);
      m_wr_thr = sat(thr_wdata_i[25:16], 32);
    end
    if (en_we_i) m_en = en_wdata_i & 32'h1000_DE00;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check({tag, " thr/req"}, thr_rdata_o, exp_thr());
    check({tag, " en"}, en_rdata_o, m_en);
    check({tag, " irq R9"}, {31'b0, irq_o}, {31'b0, exp_irq(m_req, m_en)});
    check({tag, " status R10"}, {30'b0, stat_wr_full_o, stat_rd_empty_o},
          {30'b0, wr_level_i >= 32, rd_level_i == 0});
  endtask

  task automatic tick();
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    thr_we_i = 1'b0; en_we_i = 1'b0; xfer_term_i = 1'b0; bus_tmo_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_rd_thr = 10'd8; m_wr_thr = 10'd24; m_req = '0; m_en = '0;
    #(CLK_PERIOD * 3);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1 thr reg", thr_rdata_o, 32'h0018_0008);
    check("R1 en reg", en_rdata_o, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    // R2 saturation
    thr_we_i = 1'b1; thr_wdata_i = 32'h03FF_03FF; tick();
    check("R2 sat thresholds", thr_rdata_o & 32'h03FF_03FF, 32'h0020_0008);
    thr_we_i = 1'b1; thr_wdata_i = 32'h0005_0003; tick();
    check("R2 load thresholds", thr_rdata_o & 32'h03FF_03FF, 32'h0005_0003);

    // R3 read comparisons at threshold 3
    rd_level_i = 6'd2; wr_level_i = 6'd6; tick(); compare_all("R3 R4 below");
    rd_level_i = 6'd3; wr_level_i = 6'd5; tick(); compare_all("R3 R4 at thr");
    check("R3 af set", {31'b0, thr_rdata_o[10]}, 32'h1);

    // R7 clear with live condition: 0 then back to 1
    thr_we_i = 1'b1; thr_wdata_i = 32'h0005_0403; tick();
    check("R7 cleared", {31'b0, thr_rdata_o[10]}, 32'h0);
    compare_all("R7 clr");
    tick();
    check("R7 reassert", {31'b0, thr_rdata_o[10]}, 32'h1);

    // R5 device line, R6 sticky events
    dev_irq_i = 1'b1; xfer_term_i = 1'b1; tick(); compare_all("R5 R6 set");
    dev_irq_i = 1'b0; tick(); tick();
    check("R6 term sticky", {31'b0, thr_rdata_o[28]}, 32'h1);
    bus_tmo_i = 1'b1; tick(); tick();
    check("R6 tmo sticky", {31'b0, thr_rdata_o[29]}, 32'h1);

    // R8 event in clear cycle survives; R7 write 0 leaves bit
    thr_we_i = 1'b1; thr_wdata_i = 32'h2005_0003; bus_tmo_i = 1'b1; tick();
    check("R8 tmo kept", {31'b0, thr_rdata_o[29]}, 32'h1);
    check("R7 zero write keeps term", {31'b0, thr_rdata_o[28]}, 32'h1);
    thr_we_i = 1'b1; thr_wdata_i = 32'h3005_0003; tick();
    check("R7 events cleared", {30'b0, thr_rdata_o[29:28]}, 32'h0);

    // R11 enable mask, R9 masking
    en_we_i = 1'b1; en_wdata_i = 32'hFFFF_FFFF; tick();
    check("R11 en mask", en_rdata_o, 32'h1000_DE00);
    compare_all("R9 all en");
    en_we_i = 1'b1; en_wdata_i = 32'h0000_4000; tick();
    check("R9 tmo only en, no tmo", {31'b0, irq_o}, 32'h0);
    bus_tmo_i = 1'b1; tick();
    check("R9 tmo via en14", {31'b0, irq_o}, 32'h1);

    // R10 / R4 extremes
    rd_level_i = 6'd0; wr_level_i = 6'd32; tick(); compare_all("R10 R4 full empty");
    tick(); compare_all("R4 R3 settled");

    // random mix
    for (int k = 0; k < 600; k++) begin
      rd_level_i  = 6'($urandom_range(0, 32));
      wr_level_i  = 6'($urandom_range(0, 32));
      dev_irq_i   = ($urandom_range(0, 3) == 0);
      xfer_term_i = ($urandom_range(0, 15) == 0);
      bus_tmo_i   = ($urandom_range(0, 15) == 0);
      thr_we_i    = ($urandom_range(0, 5) == 0);
      thr_wdata_i = $urandom();
      en_we_i     = ($urandom_range(0, 9) == 0);
      en_wdata_i  = $urandom();
      tick();
      compare_all("R3 R4 R5 R6 R7 R8 rand");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule